// File: doc/BRIEF.md
# Tiny Four-Register 8-Bit Processor Core

This block is a minimal multicycle processor core. It holds four 8-bit general registers, an 8-bit program counter and an instruction register. It reads one 8-bit instruction word at a time from a synchronous instruction-memory port. It can write bytes to a 16-entry data memory. The instruction set has four operations: load a small immediate, add two registers, store a register, and halt.

Each instruction passes through four control states in order: request, fetch, decode and execute. In the request state the core presents the program counter on the instruction-read port. In the fetch state the returned word is latched into the instruction register and the program counter steps by one. In the decode state the fields are registered. In the execute state the register file or the data memory is written, or the core halts.

A combinational debug port reads out any register, so a bench or a debugger can inspect the register file.

Top module: `tiny_cpu8`

## Requirements
- R1: While reset is asserted, all four registers read 0, `halted` is low and `imem_addr` is 0. After reset, the first instruction is fetched from address 0.
- R2: Each instruction takes exactly four clock cycles. `imem_en` is high for one cycle at the start of each instruction, with `imem_addr` equal to the program counter. The program counter then steps by one and wraps from 255 to 0.
- R3: Opcode bits [7:6] = 00 is LOAD. It writes the immediate in bits [3:0], zero-extended to 8 bits, into the register selected by bits [5:4].
- R4: Opcode 01 is ADD. It writes dst + src modulo 256 into the register selected by bits [5:4]. Bits [1:0] select the source register, and bits [3:2] are ignored.
- R5: Opcode 10 is STORE. In the fourth cycle of the instruction it pulses `dmem_we` for one cycle, with `dmem_addr` = bits [3:0] and `dmem_wdata` = the register selected by bits [5:4]. No register changes.
- R6: Opcode 11 is HALT. `halted` rises in the fourth cycle of the instruction and stays high until reset. While halted there are no instruction fetches, no data-memory writes and no register writes.
- R7: `dbg_data` always shows the register selected by `dbg_sel`.
- R8: The program 0x15, 0x23, 0x52 leaves register 1 equal to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_en | output | 1 | Instruction read request |
| imem_addr | output | 8 | Instruction address (program counter) |
| imem_rdata | input | 8 | Instruction word, valid the cycle after the request |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_addr | output | 4 | Data-memory write address |
| dmem_wdata | output | 8 | Data-memory write data |
| halted | output | 1 | Core has executed HALT |
| dbg_sel | input | 2 | Register select for debug read-out |
| dbg_data | output | 8 | Selected register value |

## Verification
Reset release passes through a two-stage synchronizer. The first instruction therefore completes on the sixth rising edge after reset is deasserted, and each later instruction completes four edges after the one before it.

The bench waits out the synchronizer. It then samples on the falling edge after the third edge of each instruction, where the store strobe or `halted` must appear. It samples again after the fourth edge, where register results, the stored byte and the next fetch address are due.

The program-counter wrap is checked after exactly 256 instructions, and the wrap of the register sum two instructions later.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int WORD_W  = 8;
  localparam int REG_CNT = 4;
  localparam int RSEL_W  = $clog2(REG_CNT);
  localparam int IMM_W   = 4;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_HALT  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_REQ,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_HALT
  } state_e;

  typedef struct packed {
    op_e               op;
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src;
    logic [IMM_W-1:0]  imm;
  } dec_t;

  function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
    dec_t d;
    d.op  = op_e'(w[7:6]);
    d.dst = w[5:4];
    d.src = w[1:0];
    d.imm = w[3:0];
    return d;
  endfunction
endpackage

// File: rtl/tcpu_rst_sync.sv
module tcpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile
  import tcpu_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = REG_CNT,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] ra,
  output logic [W-1:0]  rda,
  input  logic [SW-1:0] rb,
  output logic [W-1:0]  rdb,
  input  logic [SW-1:0] rdbg,
  output logic [W-1:0]  rddbg
);
  logic [N-1:0][W-1:0] regs;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic         en;
    logic [W-1:0] q;

    assign en = we && (waddr == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end

    assign regs[i] = q;
  end

  assign rda   = regs[ra];
  assign rdb   = regs[rb];
  assign rddbg = regs[rdbg];
endmodule

// File: rtl/tcpu_adder.sv
module tcpu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  // Ripple chain; the carry out of the top bit is never formed, so results wrap.
  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p      = a[i] ^ b[i];
    assign sum[i] = p ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & p);
    end
  end
endmodule

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
  import tcpu_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic              imem_en,
  output logic [PC_W-1:0]   imem_addr,
  output logic              ir_load,
  output logic              exec,
  output dec_t              dec,
  output logic              halted
);
  state_e            state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [WORD_W-1:0] ir_q;
  dec_t              dec_q;
  logic              dec_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REQ:    state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = (dec_q.op == OP_HALT) ? ST_HALT : ST_REQ;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  assign ir_load = (state_q == ST_FETCH);
  assign dec_en  = (state_q == ST_DECODE);
  assign pc_d    = pc_q + PC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_REQ;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (ir_load) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir_q <= '0;
    else if (ir_load) ir_q <= imem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dec_q <= '0;
    else if (dec_en) dec_q <= decode_word(ir_q);
  end

  assign imem_en   = (state_q == ST_REQ);
  assign imem_addr = pc_q;
  assign exec      = (state_q == ST_EXEC);
  assign dec       = dec_q;
  assign halted    = (state_q == ST_HALT) || (exec && dec_q.op == OP_HALT);
endmodule

// File: rtl/tiny_cpu8.sv
module tiny_cpu8
  import tcpu_pkg::*;
#(
  parameter int PC_W        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DADDR_W    = IMM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               imem_en,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [WORD_W-1:0]  imem_rdata,
  output logic               dmem_we,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  output logic               halted,
  input  logic [RSEL_W-1:0]  dbg_sel,
  output logic [WORD_W-1:0]  dbg_data
);
  logic              rst_sync_n;
  logic              ir_load;
  logic              exec;
  dec_t              dec;
  logic              rf_we;
  logic [WORD_W-1:0] rf_wdata;
  logic [WORD_W-1:0] rd_dst;
  logic [WORD_W-1:0] rd_src;
  logic [WORD_W-1:0] sum;

  tcpu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tcpu_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .imem_rdata (imem_rdata),
    .imem_en    (imem_en),
    .imem_addr  (imem_addr),
    .ir_load    (ir_load),
    .exec       (exec),
    .dec        (dec),
    .halted     (halted)
  );

  tcpu_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (rf_we),
    .waddr (dec.dst),
    .wdata (rf_wdata),
    .ra    (dec.dst),
    .rda   (rd_dst),
    .rb    (dec.src),
    .rdb   (rd_src),
    .rdbg  (dbg_sel),
    .rddbg (dbg_data)
  );

  tcpu_adder #(.W(WORD_W)) u_add (
    .a   (rd_dst),
    .b   (rd_src),
    .sum (sum)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = sum;
    if (exec) begin
      unique case (dec.op)
        OP_LOAD: begin
          rf_we    = 1'b1;
          rf_wdata = {{(WORD_W-IMM_W){1'b0}}, dec.imm};
        end
        OP_ADD:  rf_we = 1'b1;
        default: rf_we = 1'b0;
      endcase
    end
  end

  assign dmem_we    = exec && (dec.op == OP_STORE);
  assign dmem_addr  = dec.imm;
  assign dmem_wdata = rd_dst;
endmodule

// File: rtl/tcpu_checker.sv
module tcpu_checker #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imem_en,
  input logic [PC_W-1:0] imem_addr,
  input logic            ir_load,
  input logic            dmem_we,
  input logic            halted,
  input logic            rf_we
);
  p_single_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |=> !imem_en);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (imem_addr == PC_W'($past(imem_addr) + PC_W'(1))));

  p_store_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);

  p_store_no_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !rf_we);

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_no_fetch_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halted) |-> !imem_en);

  p_no_store_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halted) |-> !dmem_we);

  p_no_regwr_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halted) |-> !rf_we);
endmodule

bind tiny_cpu8 tcpu_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .imem_en   (imem_en),
  .imem_addr (imem_addr),
  .ir_load   (ir_load),
  .dmem_we   (dmem_we),
  .halted    (halted),
  .rf_we     (rf_we)
);

// File: tb/sim_tiny_cpu8.sv
`timescale 1ns/1ps
module sim_tiny_cpu8;
  localparam int NVEC = 16;
  localparam int SYNC = 2;

  // {instruction, register to inspect, expected value}; stores check memory instead
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h15, 2'd1, 8'd5},    // LOAD R1,5
    {8'h23, 2'd2, 8'd3},    // LOAD R2,3
    {8'h52, 2'd1, 8'd8},    // ADD R1,R2 -> 8
    {8'h0F, 2'd0, 8'd15},   // LOAD R0,15
    {8'h3A, 2'd3, 8'd10},   // LOAD R3,10
    {8'h70, 2'd3, 8'd25},   // ADD R3,R0
    {8'h73, 2'd3, 8'd50},   // ADD R3,R3
    {8'h73, 2'd3, 8'd100},
    {8'h73, 2'd3, 8'd200},
    {8'h73, 2'd3, 8'd144},  // 400 mod 256
    {8'hB7, 2'd0, 8'd144},  // STORE R3 -> [7]
    {8'h80, 2'd0, 8'd15},   // STORE R0 -> [0]
    {8'h9F, 2'd0, 8'd8},    // STORE R1 -> [15]
    {8'h41, 2'd0, 8'd23},   // ADD R0,R1
    {8'h45, 2'd0, 8'd31},   // ADD R0,R1 with bits [3:2]=01 ignored
    {8'h22, 2'd2, 8'd2}     // LOAD R2,2
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       imem_en;
  logic [7:0] imem_addr;
  logic [7:0] imem_rdata;
  logic       dmem_we;
  logic [3:0] dmem_addr;
  logic [7:0] dmem_wdata;
  logic       halted;
  logic [1:0] dbg_sel;
  logic [7:0] dbg_data;

  logic [7:0] imem [256];
  logic [7:0] dmem [16];
  int checks = 0;
  int fails  = 0;
  int halted_acts = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tiny_cpu8 u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .halted(halted), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always @(posedge clk) begin
    if (imem_en) imem_rdata <= imem[imem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (halted && (dmem_we || imem_en)) halted_acts <= halted_acts + 1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] r, output logic [7:0] v);
    dbg_sel = r;
    #1;
    v = dbg_data;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0;
    dbg_sel = 2'd0;
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    for (int i = 0; i < 16; i++) dmem[i] = 8'h00;
    for (int k = 0; k < NVEC; k++) imem[k] = VEC[k][17:10];
    imem[NVEC]   = 8'hC0;  // HALT
    imem[NVEC+1] = 8'h0A;  // LOAD R0,10 must not run
    imem[NVEC+2] = 8'h81;  // STORE R0 -> [1] must not run

    repeat (3) @(negedge clk);
    // R1: reset state
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), v);
      chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset halted", {7'd0, halted}, 8'd0);
    chk("R1 reset pc", imem_addr, 8'd0);

    rst_n = 1'b1;
    repeat (SYNC) @(posedge clk);

    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] ins;
      string tag;
      ins = VEC[k][17:10];
      case (ins[7:6])
        2'b00:   tag = "R3 load";
        2'b01:   tag = "R4 add";
        default: tag = "R5 store";
      endcase
      if (k == 2) tag = "R8 program";
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2 no fetch in execute", {7'd0, imem_en}, 8'd0);
      chk("R5 store strobe", {7'd0, dmem_we}, {7'd0, ins[7:6] == 2'b10});
      if (ins[7:6] == 2'b10) chk("R5 store addr", {4'd0, dmem_addr}, {4'd0, ins[3:0]});
      @(posedge clk);
      @(negedge clk);
      if (ins[7:6] == 2'b10) begin
        chk(tag, dmem[ins[3:0]], VEC[k][7:0]);
      end else begin
        rd(VEC[k][9:8], v);
        chk(tag, v, VEC[k][7:0]);
      end
      chk("R2 next fetch", {7'd0, imem_en}, 8'd1);
      chk("R2 pc step", imem_addr, 8'(k + 1));
    end

    // R6: HALT visible in its execute cycle, then sticky with no side effects
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 halted in execute", {7'd0, halted}, 8'd1);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R6 halted sticky", {7'd0, halted}, 8'd1);
    chk("R6 no fetch", {7'd0, imem_en}, 8'd0);
    chk("R6 no store after halt", dmem[1], 8'h00);
    chk("R6 no activity", 8'(halted_acts), 8'd0);

    // R7: debug read-out of every register
    rd(2'd0, v); chk("R7 dbg R0", v, 8'd31);
    rd(2'd1, v); chk("R7 dbg R1", v, 8'd8);
    rd(2'd2, v); chk("R7 dbg R2", v, 8'd2);
    rd(2'd3, v); chk("R6 R3 kept / R7 dbg R3", v, 8'd144);

    // R1: reset while halted clears state
    rst_n = 1'b0;
    #1;
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), v);
      chk("R1 reset clears reg", v, 8'h00);
    end
    chk("R1 reset clears halted", {7'd0, halted}, 8'd0);

    // R2 wrap / R4 wrap: R1=1 then 255 increments of R0
    imem[0] = 8'h11;
    for (int i = 1; i < 256; i++) imem[i] = 8'h41;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (SYNC) @(posedge clk);
    repeat (256 * 4) @(posedge clk);
    @(negedge clk);
    rd(2'd0, v);
    chk("R4 add chain", v, 8'd255);
    chk("R2 pc wrap", imem_addr, 8'd0);
    repeat (8) @(posedge clk);
    @(negedge clk);
    rd(2'd0, v);
    chk("R4 add wraps", v, 8'd0);
    chk("R2 pc after wrap", imem_addr, 8'd2);

    done = 1;
    finish_run();
  end
endmodule